// File: doc/BRIEF.md
# Sampling Converter Control Interface

This block is the digital front door of a 12-bit sampling converter. A host starts a conversion by pulling the read/convert line from high to low. The chip-select and high-byte-select lines must both be low when that edge arrives. An active-low busy output then stays low for a fixed number of clock cycles, set by a parameter. During that window every control input is ignored. When the window closes, the value on the sample input is captured as the new result.

The result is read out while read/convert is high, chip-select is low and busy is high. It can be read as one 12-bit word or, on a byte-wide bus, as two bytes chosen by the high-byte-select line. The three-state bus is modelled as a data vector plus a separate enable. The data vector is zero whenever the enable is low.

Hosts can use either polarity of start pulse. A negative pulse starts a conversion, and the data is read after busy returns high. A positive pulse first reads the previous result during its high phase, and its falling edge then starts the next conversion.

Top module: `adc_ctrl_if`

## Requirements
- R1: A conversion starts only when all of these hold: read/convert was high in the previous sampled cycle and is low in the current one, chip-select is low, high-byte-select is low, and busy is high. Busy goes low on the next clock.
- R2: No other input combination or transition starts a conversion. In particular, a high chip-select or a high high-byte-select during the falling edge leaves busy high.
- R3: Once a conversion starts, busy stays low for exactly CONV_CYCLES consecutive clock cycles and then returns high.
- R4: While busy is low, changes on chip-select, read/convert and high-byte-select neither stop nor restart the conversion. The busy window keeps its length, and an edge seen inside the window does not start a new conversion after it.
- R5: The output enable is high exactly when read/convert is high, busy is high and chip-select is low. Whenever the enable is low, the data vector is all zeros, so the bus is never enabled during a conversion.
- R6: In word format (byte-mode input low), an enabled bus carries all 12 result bits on data bits 11:0.
- R7: In byte format with high-byte-select low, data bits 7:0 carry result bits 7:0 and data bits 11:8 are 0.
- R8: In byte format with high-byte-select high, data bits 7:4 carry result bits 11:8, and data bits 3:0 and 11:8 are 0.
- R9: The result register changes only at the end of a conversion. It takes the value of the sample input on the last clock of the busy window. Reads made before a conversion ends return the previous result.
- R10: After reset, busy is high, the result is zero, and no falling edge is pending, so holding read/convert low out of reset starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select, active low |
| rd_conv_i | input | 1 | Read (high) / convert on falling edge |
| hbe_i | input | 1 | High-byte select; blocks a start when high |
| byte_mode_i | input | 1 | 1 = byte-wide output format, 0 = 12-bit word |
| sample_i | input | RES_W | Result supplied by the conversion engine stub |
| busy_n_o | output | 1 | Low while a conversion runs |
| oe_o | output | 1 | Data bus enable |
| data_o | output | RES_W | Data bus value, zero when oe_o is low |

## Verification
Start qualification is tried with falling edges under every blocking condition: chip-select high, high-byte-select high, an edge inside the busy window, and read/convert held low out of reset. This separates the qualified-edge rule from a simple level or edge trigger. Both pulse polarities are used. The positive pulse shows that the old result is read before the new conversion. The negative pulse shows that the new value appears after busy returns. The control lines and the sample input are toggled throughout a conversion, which separates capture at the end of the window from capture at the start or midway. Reads in word format and in both byte halves, with distinct bit patterns, expose lane placement and zero forcing.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    typedef enum logic [1:0] {
        FMT_WORD = 2'd0,
        FMT_LOW  = 2'd1,
        FMT_HIGH = 2'd2
    } lane_fmt_e;

    typedef struct packed {
        logic rc_prev;
    } qual_state_t;

endpackage

// File: rtl/adc_start_qual.sv
module adc_start_qual
    import adc_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic rc_i,
    input  logic hbe_i,
    input  logic busy_i,
    output logic start_o
);

    qual_state_t st_d, st_q;
    logic        fall;

    always_comb begin
        st_d         = st_q;
        st_d.rc_prev = rc_i;
        fall         = st_q.rc_prev & ~rc_i;
        start_o      = fall & ~cs_n_i & ~hbe_i & ~busy_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rc_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
    parameter int RES_W       = 12,
    parameter int CONV_CYCLES = 270
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [RES_W-1:0] sample_i,
    output logic             busy_o,
    output logic [RES_W-1:0] result_o
);

    localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [RES_W-1:0] result;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy   = 1'b0;
                st_d.result = sample_i;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (start_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy   <= 1'b0;
            st_q.cnt    <= '0;
            st_q.result <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = st_q.busy;
    assign result_o = st_q.result;

endmodule

// File: rtl/adc_out_fmt.sv
module adc_out_fmt
    import adc_ctrl_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic [RES_W-1:0] result_i,
    input  logic             busy_i,
    input  logic             cs_n_i,
    input  logic             rc_i,
    input  logic             hbe_i,
    input  logic             byte_mode_i,
    output logic             oe_o,
    output logic [RES_W-1:0] data_o
);

    localparam int HI_W   = RES_W - 8;
    localparam int LO_PAD = 8 - HI_W;

    lane_fmt_e        fmt;
    logic [7:0]       lo_lane;
    logic [7:0]       hi_lane;
    logic [RES_W-1:0] shaped;

    assign lo_lane = result_i[7:0];

    generate
        if (LO_PAD > 0) begin : g_pad
            assign hi_lane = {result_i[RES_W-1:8], {LO_PAD{1'b0}}};
        end else begin : g_nopad
            assign hi_lane = result_i[RES_W-1:8];
        end
    endgenerate

    always_comb begin
        if (!byte_mode_i)  fmt = FMT_WORD;
        else if (!hbe_i)   fmt = FMT_LOW;
        else               fmt = FMT_HIGH;

        unique case (fmt)
            FMT_LOW:  shaped = {{HI_W{1'b0}}, lo_lane};
            FMT_HIGH: shaped = {{HI_W{1'b0}}, hi_lane};
            default:  shaped = result_i;
        endcase

        oe_o   = rc_i & ~busy_i & ~cs_n_i;
        data_o = oe_o ? shaped : '0;
    end

endmodule

// File: rtl/adc_ctrl_if.sv
module adc_ctrl_if #(
    parameter int RES_W       = 12,
    parameter int CONV_CYCLES = 270
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_i,
    input  logic             rd_conv_i,
    input  logic             hbe_i,
    input  logic             byte_mode_i,
    input  logic [RES_W-1:0] sample_i,
    output logic             busy_n_o,
    output logic             oe_o,
    output logic [RES_W-1:0] data_o
);

    logic             start;
    logic             busy;
    logic [RES_W-1:0] result;

    adc_start_qual u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_i  (cs_n_i),
        .rc_i    (rd_conv_i),
        .hbe_i   (hbe_i),
        .busy_i  (busy),
        .start_o (start)
    );

    adc_conv_timer #(
        .RES_W       (RES_W),
        .CONV_CYCLES (CONV_CYCLES)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .sample_i (sample_i),
        .busy_o   (busy),
        .result_o (result)
    );

    adc_out_fmt #(
        .RES_W (RES_W)
    ) u_fmt (
        .result_i    (result),
        .busy_i      (busy),
        .cs_n_i      (cs_n_i),
        .rc_i        (rd_conv_i),
        .hbe_i       (hbe_i),
        .byte_mode_i (byte_mode_i),
        .oe_o        (oe_o),
        .data_o      (data_o)
    );

    assign busy_n_o = ~busy;

endmodule

// File: rtl/adc_ctrl_chk.sv
module adc_ctrl_chk #(
    parameter int RES_W       = 12,
    parameter int CONV_CYCLES = 270
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n_i,
    input logic             rd_conv_i,
    input logic             hbe_i,
    input logic             byte_mode_i,
    input logic [RES_W-1:0] sample_i,
    input logic             busy_n_o,
    input logic             oe_o,
    input logic [RES_W-1:0] data_o
);

    logic        rc_seen_q;
    int unsigned low_run_q;
    logic        qual;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rc_seen_q <= 1'b0;
            low_run_q <= 0;
        end else begin
            rc_seen_q <= rd_conv_i;
            low_run_q <= busy_n_o ? 0 : low_run_q + 1;
        end
    end

    assign qual = busy_n_o && rc_seen_q && !rd_conv_i && !cs_n_i && !hbe_i;

    AST_START_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        qual |=> !busy_n_o); // R1

    AST_NO_SPURIOUS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n_o && !qual) |=> busy_n_o); // R2

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n_o) |-> (low_run_q == CONV_CYCLES)); // R3

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (low_run_q <= CONV_CYCLES)); // R4

    AST_HIZ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_n_o |-> (!oe_o && data_o == '0)); // R5

    AST_LOW_BYTE_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o && byte_mode_i && !hbe_i) |-> (data_o[RES_W-1:8] == '0)); // R7

    AST_HIGH_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o && byte_mode_i && hbe_i) |-> (data_o[3:0] == '0 && data_o[RES_W-1:8] == '0)); // R8

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n_o && $past(busy_n_o) && oe_o && $past(oe_o)
         && $stable(hbe_i) && $stable(byte_mode_i)) |-> $stable(data_o)); // R9

endmodule

bind adc_ctrl_if adc_ctrl_chk #(
    .RES_W       (RES_W),
    .CONV_CYCLES (CONV_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n_i      (cs_n_i),
    .rd_conv_i   (rd_conv_i),
    .hbe_i       (hbe_i),
    .byte_mode_i (byte_mode_i),
    .sample_i    (sample_i),
    .busy_n_o    (busy_n_o),
    .oe_o        (oe_o),
    .data_o      (data_o)
);

// File: tb/sim_adc_ctrl_if.sv
module sim_adc_ctrl_if;

    localparam int W  = 12;
    localparam int NC = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b0;
    logic         rc = 1'b0;
    logic         hbe = 1'b0;
    logic         bmode = 1'b0;
    logic [W-1:0] smp = '0;
    logic         busy_n;
    logic         oe;
    logic [W-1:0] data;

    int    checks = 0;
    int    errors = 0;
    string req = "R10";
    bit    done = 1'b0;

    // reference model state
    int           m_busy = 0;
    int           m_cnt = 0;
    logic [W-1:0] m_res = '0;
    int           m_prev = 0;
    int           low_len = 0;
    int           last_len = -1;

    always #2 clk = ~clk;

    adc_ctrl_if #(.RES_W(W), .CONV_CYCLES(NC)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .rd_conv_i(rc), .hbe_i(hbe),
        .byte_mode_i(bmode), .sample_i(smp), .busy_n_o(busy_n), .oe_o(oe), .data_o(data)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_res = '0; m_prev = 0; low_len = 0;
        end else begin
            if (m_busy != 0) begin
                low_len++;
                if (m_cnt == 0) begin
                    m_busy = 0;
                    m_res = smp;
                    last_len = low_len;
                end else begin
                    m_cnt--;
                end
            end else if (m_prev != 0 && !rc && !cs_n && !hbe) begin
                m_busy = 1;
                m_cnt = NC - 1;
                low_len = 0;
            end
            m_prev = rc ? 1 : 0;
        end
    end

    function automatic logic [W-1:0] shape(logic [W-1:0] r);
        if (!bmode) return r;
        if (!hbe)   return {4'b0, r[7:0]};
        return {4'b0, r[11:8], 4'b0};
    endfunction

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            logic         e_oe;
            logic [W-1:0] e_dat;
            e_oe  = rc && (m_busy == 0) && !cs_n;
            e_dat = e_oe ? shape(m_res) : '0;
            chk(req, W'(busy_n), W'(m_busy == 0), "busy_n");
            chk(req, W'(oe), W'(e_oe), "oe");
            chk(req, data, e_dat, "data");
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic drv(logic c, logic r, logic h);
        cs_n = c; rc = r; hbe = h;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4 * NC && busy_n !== 1'b1; i++) step(1);
    endtask

    initial begin
        int guard = 0;
        while (!done && guard < 100000) begin
            @(posedge clk);
            guard++;
        end
        if (!done) begin
            errors++;
            $display("FAIL R3 watchdog actual running expected finished");
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: reset, rc held low out of reset starts nothing
        req = "R10";
        drv(0, 0, 0);
        step(3);
        rst_n = 1'b1;
        step(4);
        chk("R10", W'(busy_n), W'(1), "busy after reset with rc low");

        // R5 / R6: read previous (zero) result in word mode
        req = "R6";
        drv(0, 1, 0);
        step(3);
        drv(1, 1, 0);
        req = "R5";
        step(2);

        // R2: falling edges with cs high or hbe high do not start
        req = "R2";
        drv(1, 1, 0); step(2); drv(1, 0, 0); step(3);
        chk("R2", W'(busy_n), W'(1), "cs high blocks start");
        drv(0, 1, 1); step(2); drv(0, 0, 1); step(3);
        chk("R2", W'(busy_n), W'(1), "hbe high blocks start");
        drv(0, 0, 0); step(3);
        chk("R2", W'(busy_n), W'(1), "rc held low no start");

        // R1 / R3 / R4 / R9: negative pulse start, inputs toggled, sample changed
        req = "R1";
        smp = 12'h111;
        drv(0, 1, 0); step(2);
        drv(0, 0, 0); step(1);
        chk("R1", W'(busy_n), W'(0), "busy low after qualified fall");
        req = "R4";
        for (int i = 0; i < NC - 3; i++) begin
            drv(logic'(i[0]), logic'(i[1]), logic'(i[2]));
            smp = W'(12'h200 + i);
            step(1);
        end
        drv(0, 1, 0);
        smp = 12'hA5C;
        req = "R9";
        wait_idle();
        step(1);
        chk("R3", W'(last_len), W'(NC), "busy window length");
        chk("R9", data, 12'hA5C, "captured last-cycle sample");
        chk("R4", W'(busy_n), W'(1), "no restart after window");

        // R7 / R8: byte format reads
        bmode = 1'b1;
        req = "R7";
        drv(0, 1, 0); step(2);
        chk("R7", data, 12'h05C, "low byte");
        req = "R8";
        drv(0, 1, 1); step(2);
        chk("R8", data, 12'h0A0, "high nibble");
        bmode = 1'b0;

        // R9: positive pulse reads old result, then fall starts new one
        req = "R9";
        smp = 12'h3C7;
        drv(0, 1, 0); step(2);
        chk("R9", data, 12'hA5C, "old result before new conversion");
        drv(0, 0, 0); step(1);
        req = "R1";
        chk("R1", W'(busy_n), W'(0), "positive pulse start");
        drv(0, 1, 0);
        req = "R5";
        step(3);
        chk("R5", W'(oe), W'(0), "no enable while busy with rc high");
        wait_idle();
        step(1);
        req = "R6";
        chk("R6", data, 12'h3C7, "word read of new result");
        drv(1, 1, 0); step(1);
        chk("R5", W'(oe), W'(0), "cs high disables bus");
        step(2);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule